// File: doc/BRIEF.md
# PCI Configuration Cycle Initiator

This block lets a processor run one PCI configuration or I/O cycle at a time through a small set of word registers. Software fills in a target locator (bus number, device/function number and register offset) and, for writes, a data word. It then writes the control word with the start bit set. The engine builds the bus address, holds a single-beat request on a simplified request/acknowledge bus and waits for the target. It then records either a clean completion or a master abort in a sticky status word.

Bus 0 produces a type-0 address, which carries only the device/function and register fields. Any other bus number adds the bus field and sets address bit 0 to mark a type-1 cycle. The register offset is always forced to a 32-bit boundary. Byte enables are active low and come straight from the control word, so software picks them from the access size and offset. Read data, or all ones after an aborted read, is left in a read-back register. Software writes the status value back to the clear register to reset the status.

Top module: `cfg_cycle_master`

## Requirements
- R1: After reset the status word, the read-back register and the control readback are zero, and `bus_req` is low.
- R2: Register index 0 holds the locator: offset in bits [7:0], device/function in [15:8], bus number in [23:16]. The bus address carries device/function at bits [15:8], the offset with bits [1:0] cleared at [7:0], and zero elsewhere. A nonzero bus number also places the bus number at [23:16] and sets bit 0.
- R3: A write to index 3 with bit 0 set, while idle, launches one cycle. `bus_req` rises the next cycle with `bus_cmd` from control bits [7:4], `bus_be_n` from control bits [11:8] unchanged, and `bus_wdata` from the data word at index 1. All of these are captured at launch and stay stable while the request is held.
- R4: When `bus_ack` is high during a request cycle, the request ends and status bit 0 (done) sets on the following cycle.
- R5: Command codes 0x2 (I/O read) and 0xA (configuration read) load `bus_rdata` into the read-back register at index 2 on success. Codes 0x3 and 0xB (writes) leave it unchanged.
- R6: If no acknowledge arrives within TIMEOUT request cycles (default 6), the request drops and status bit 1 (master abort) sets instead of done. An acknowledge in the last allowed cycle still completes normally.
- R7: An aborted read loads 0xFFFFFFFF into the read-back register. An aborted write leaves it unchanged.
- R8: Status bit 2 (busy) is high from the cycle after launch until the cycle ends. A start written while busy is ignored: no second bus cycle runs and the running cycle's command is kept.
- R9: A write to index 5 clears each of status bits 0 and 1 where the written bit is 1 and leaves the others. Writing the status value back returns the status to zero.
- R10: Reading index 3 returns the last written command and byte-enable fields in their write positions, with bit 0 reading as 0. Writing the control word with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_req | output | 1 | Request held for the single-beat cycle |
| bus_addr | output | 32 | Formed bus address |
| bus_cmd | output | 4 | Bus command code |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Write data for the cycle |
| bus_ack | input | 1 | Target acknowledge |
| bus_rdata | input | 32 | Target read data, valid with `bus_ack` |

## Verification
The bench aims at the timeout edge, with an acknowledge in the sixth request cycle and again in the seventh. An off-by-one counter would either abort a good cycle or accept a late one. It compares type-0 against type-1 addresses and uses offsets with their low bits set, so a design that leaks the bus field or the offset bits into a bus-0 address is caught. It checks the read-back register after aborted reads, successful writes and aborted writes, which catches a design that fills with ones on writes or overwrites data on writes. It fires a second start during a busy cycle and clears status bits one at a time, so a re-launch, a lost command or a clear-all shows up in the transaction count or the status word.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

   // register word indices
   localparam logic [2:0] RIX_LOC  = 3'd0;
   localparam logic [2:0] RIX_WDAT = 3'd1;
   localparam logic [2:0] RIX_RDAT = 3'd2;
   localparam logic [2:0] RIX_CTRL = 3'd3;
   localparam logic [2:0] RIX_STAT = 3'd4;
   localparam logic [2:0] RIX_CLR  = 3'd5;

   // command codes
   localparam logic [3:0] CMD_IO_RD = 4'h2;
   localparam logic [3:0] CMD_IO_WR = 4'h3;
   localparam logic [3:0] CMD_CF_RD = 4'hA;
   localparam logic [3:0] CMD_CF_WR = 4'hB;

   // status bit positions
   localparam int ST_DONE  = 0;
   localparam int ST_ABORT = 1;
   localparam int ST_BUSY  = 2;

   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_REQ  = 1'b1
   } sq_state_t;

   typedef struct packed {
      logic [7:0] bus;
      logic [7:0] devfn;
      logic [7:0] offs;
   } locator_t;

   function automatic logic cmd_is_read(input logic [3:0] c);
      return (c == CMD_IO_RD) || (c == CMD_CF_RD);
   endfunction

endpackage

// File: rtl/cfgm_addr_form.sv
module cfgm_addr_form
   import cfgm_pkg::*;
#(
   parameter int DW      = 32,
   parameter int BUS_LSB = 16,
   parameter int FN_LSB  = 8
) (
   input  locator_t          loc,
   output logic [DW-1:0]     addr
);

   if (FN_LSB < 8) begin : g_bad_fn
      $error("device/function field overlaps the register offset");
   end
   if (BUS_LSB < FN_LSB + 8) begin : g_bad_bus
      $error("bus field overlaps the device/function field");
   end
   if (BUS_LSB + 8 > DW) begin : g_bad_width
      $error("bus field does not fit the address width");
   end

   logic type1;
   assign type1 = (loc.bus != 8'd0);

   always_comb begin
      addr              = '0;
      addr[7:2]         = loc.offs[7:2];
      addr[FN_LSB +: 8] = loc.devfn;
      if (type1) begin
         addr[BUS_LSB +: 8] = loc.bus;
         addr[0]            = 1'b1;
      end
   end

endmodule

// File: rtl/cfgm_seq.sv
module cfgm_seq
   import cfgm_pkg::*;
#(
   parameter int DW      = 32,
   parameter int TIMEOUT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    cmd_in,
   input  logic [3:0]    be_in,
   input  logic [DW-1:0] addr_in,
   input  logic [DW-1:0] wdat_in,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_req,
   output logic [DW-1:0] bus_addr,
   output logic [3:0]    bus_cmd,
   output logic [3:0]    bus_be_n,
   output logic [DW-1:0] bus_wdata,
   output logic          busy,
   output logic          done_set,
   output logic          abort_set,
   output logic          rd_load,
   output logic [DW-1:0] rd_val
);

   if (TIMEOUT < 1) begin : g_bad_tmo
      $error("TIMEOUT must be at least one cycle");
   end

   sq_state_t     state;
   logic [3:0]    cmd_q;
   logic [3:0]    be_q;
   logic [DW-1:0] addr_q;
   logic [DW-1:0] wdat_q;
   logic          expire;
   logic          in_req;

   assign in_req = (state == SQ_REQ);

   // timeout variant chosen by parameter
   if (TIMEOUT == 1) begin : g_tmo_single
      assign expire = 1'b1;
   end else begin : g_tmo_count
      localparam int CNT_W = $clog2(TIMEOUT);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (!in_req)
            cnt <= '0;
         else if (!bus_ack)
            cnt <= cnt + 1'b1;
      end
      assign expire = (cnt == CNT_W'(TIMEOUT - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cmd_q  <= '0;
         be_q   <= '0;
         addr_q <= '0;
         wdat_q <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  state  <= SQ_REQ;
                  cmd_q  <= cmd_in;
                  be_q   <= be_in;
                  addr_q <= addr_in;
                  wdat_q <= wdat_in;
               end
            end
            SQ_REQ: begin
               if (bus_ack || expire)
                  state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign done_set  = in_req && bus_ack;
   assign abort_set = in_req && !bus_ack && expire;
   assign rd_load   = cmd_is_read(cmd_q) && (done_set || abort_set);
   assign rd_val    = done_set ? bus_rdata : '1;

   assign busy      = in_req;
   assign bus_req   = in_req;
   assign bus_addr  = addr_q;
   assign bus_cmd   = cmd_q;
   assign bus_be_n  = be_q;
   assign bus_wdata = wdat_q;

endmodule

// File: rtl/cfgm_regs.sv
module cfgm_regs
   import cfgm_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          busy,
   input  logic          done_set,
   input  logic          abort_set,
   input  logic          rd_load,
   input  logic [DW-1:0] rd_val,
   output locator_t      loc_q,
   output logic [DW-1:0] wdat_q,
   output logic [3:0]    ctrl_cmd,
   output logic [3:0]    ctrl_be,
   output logic          start_pulse,
   output logic          st_done,
   output logic          st_abort
);

   if (DW < 24) begin : g_bad_dw
      $error("data width must hold the locator fields");
   end

   localparam int NST = 2;

   logic [DW-1:0]  rdat_q;
   logic [NST-1:0] st_q;
   logic [NST-1:0] st_d;
   logic [NST-1:0] st_set;
   logic           clr_hit;

   assign clr_hit     = reg_we && (reg_addr == RIX_CLR);
   assign start_pulse = reg_we && (reg_addr == RIX_CTRL) && reg_wdata[0];
   assign st_set      = {abort_set, done_set};

   always_comb begin
      for (int i = 0; i < NST; i++) begin
         if (st_set[i])
            st_d[i] = 1'b1;
         else if (clr_hit && reg_wdata[i])
            st_d[i] = 1'b0;
         else
            st_d[i] = st_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_q    <= '0;
         wdat_q   <= '0;
         rdat_q   <= '0;
         ctrl_cmd <= '0;
         ctrl_be  <= '0;
         st_q     <= '0;
      end else begin
         st_q <= st_d;
         if (reg_we && reg_addr == RIX_LOC)
            loc_q <= reg_wdata[23:0];
         if (reg_we && reg_addr == RIX_WDAT)
            wdat_q <= reg_wdata;
         if (reg_we && reg_addr == RIX_CTRL) begin
            ctrl_cmd <= reg_wdata[7:4];
            ctrl_be  <= reg_wdata[11:8];
         end
         if (rd_load)
            rdat_q <= rd_val;
      end
   end

   assign st_done  = st_q[ST_DONE];
   assign st_abort = st_q[ST_ABORT];

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RIX_LOC:  reg_rdata[23:0] = loc_q;
         RIX_WDAT: reg_rdata = wdat_q;
         RIX_RDAT: reg_rdata = rdat_q;
         RIX_CTRL: reg_rdata[11:4] = {ctrl_be, ctrl_cmd};
         RIX_STAT: reg_rdata[2:0] = {busy, st_q};
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cfg_cycle_master.sv
module cfg_cycle_master
   import cfgm_pkg::*;
#(
   parameter int DW      = 32,
   parameter int TIMEOUT = 6,
   parameter int BUS_LSB = 16,
   parameter int FN_LSB  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          bus_req,
   output logic [31:0]   bus_addr,
   output logic [3:0]    bus_cmd,
   output logic [3:0]    bus_be_n,
   output logic [31:0]   bus_wdata,
   input  logic          bus_ack,
   input  logic [31:0]   bus_rdata
);

   if (DW != 32) begin : g_bad_top_dw
      $error("port widths are fixed at 32 bits");
   end

   locator_t      loc_q;
   logic [DW-1:0] wdat_q;
   logic [DW-1:0] formed_addr;
   logic [3:0]    ctrl_cmd;
   logic [3:0]    ctrl_be;
   logic          start_pulse;
   logic          busy;
   logic          done_set;
   logic          abort_set;
   logic          rd_load;
   logic [DW-1:0] rd_val;
   logic          st_done;
   logic          st_abort;

   cfgm_regs #(.DW(DW)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .busy        (busy),
      .done_set    (done_set),
      .abort_set   (abort_set),
      .rd_load     (rd_load),
      .rd_val      (rd_val),
      .loc_q       (loc_q),
      .wdat_q      (wdat_q),
      .ctrl_cmd    (ctrl_cmd),
      .ctrl_be     (ctrl_be),
      .start_pulse (start_pulse),
      .st_done     (st_done),
      .st_abort    (st_abort)
   );

   cfgm_addr_form #(.DW(DW), .BUS_LSB(BUS_LSB), .FN_LSB(FN_LSB)) form_i (
      .loc  (loc_q),
      .addr (formed_addr)
   );

   cfgm_seq #(.DW(DW), .TIMEOUT(TIMEOUT)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_pulse),
      .cmd_in    (reg_wdata[7:4]),
      .be_in     (reg_wdata[11:8]),
      .addr_in   (formed_addr),
      .wdat_in   (wdat_q),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .bus_req   (bus_req),
      .bus_addr  (bus_addr),
      .bus_cmd   (bus_cmd),
      .bus_be_n  (bus_be_n),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .done_set  (done_set),
      .abort_set (abort_set),
      .rd_load   (rd_load),
      .rd_val    (rd_val)
   );

endmodule

// File: rtl/cfg_cycle_master_chk.sv
module cfg_cycle_master_chk #(
   parameter int TIMEOUT = 6,
   parameter int BUS_LSB = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_req,
   input logic        bus_ack,
   input logic [31:0] bus_addr,
   input logic [3:0]  bus_cmd,
   input logic        busy,
   input logic        done_q,
   input logic        abort_q
);

   int unsigned req_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_run <= 0;
      else if (bus_req)
         req_run <= req_run + 1;
      else
         req_run <= 0;
   end

   assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);

   assert_addr_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_addr[1] == 1'b0) &&
                  (bus_addr[0] == (bus_addr[BUS_LSB +: 8] != 8'd0)));

   assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_cmd)));

   assert_done_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(bus_req && bus_ack));

   assert_abort_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_q) |-> $past(bus_req && !bus_ack));

   assert_req_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_run <= TIMEOUT);

endmodule

bind cfg_cycle_master cfg_cycle_master_chk #(.TIMEOUT(TIMEOUT), .BUS_LSB(BUS_LSB)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_ack  (bus_ack),
   .bus_addr (bus_addr),
   .bus_cmd  (bus_cmd),
   .busy     (busy),
   .done_q   (st_done),
   .abort_q  (st_abort)
);

// File: tb/cfg_cycle_master_tb_top.sv
module cfg_cycle_master_tb_top;

   localparam int TMO = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic [3:0]  bus_cmd;
   logic [3:0]  bus_be_n;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   // target model state
   int          tgt_lat = 0;
   int          req_cnt = 0;
   int          txn_cnt = 0;
   logic [31:0] seen_addr = '0;
   logic [3:0]  seen_cmd = '0;
   logic [3:0]  seen_be = '0;
   logic [31:0] seen_wdata = '0;

   // expected state
   logic [31:0] exp_rdat = '0;
   logic [1:0]  exp_stat = '0;

   always #10 clk = ~clk;

   cfg_cycle_master #(.TIMEOUT(TMO)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .bus_req   (bus_req),
      .bus_addr  (bus_addr),
      .bus_cmd   (bus_cmd),
      .bus_be_n  (bus_be_n),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

   function automatic logic [31:0] exp_addr(input logic [23:0] loc);
      logic [31:0] a;
      a = {16'h0, loc[15:8], loc[7:2], 2'b00};
      if (loc[23:16] != 8'd0) a = a | {8'h0, loc[23:16], 16'h0} | 32'h1;
      return a;
   endfunction

   function automatic logic [31:0] tgt_data(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'hA5C3_0F96;
   endfunction

   function automatic bit is_rd(input logic [3:0] c);
      return (c == 4'h2) || (c == 4'hA);
   endfunction

   function automatic logic [3:0] be_for(input int sz, input logic [1:0] off);
      if (sz == 1) return ~(4'b0001 << off);
      if (sz == 2) return ~(4'b0011 << off);
      return 4'b0000;
   endfunction

   // target: acks in the tgt_lat-th request cycle, never if tgt_lat is 0
   always @(negedge clk) begin
      if (bus_req) begin
         req_cnt = req_cnt + 1;
         if (req_cnt == 1) begin
            txn_cnt    = txn_cnt + 1;
            seen_addr  = bus_addr;
            seen_cmd   = bus_cmd;
            seen_be    = bus_be_n;
            seen_wdata = bus_wdata;
         end
         if (req_cnt == tgt_lat) begin
            bus_ack   = 1'b1;
            bus_rdata = tgt_data(bus_addr);
         end else begin
            bus_ack = 1'b0;
         end
      end else begin
         req_cnt = 0;
         bus_ack = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_addr = idx;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output logic [31:0] s);
      int n = 0;
      do begin
         rd_reg(3'd4, s);
         n++;
      end while (s[2] && n < 40);
   endtask

   task automatic run_cycle(input logic [23:0] loc, input logic [31:0] wd,
                            input logic [3:0] cmd, input logic [3:0] be,
                            input int lat, input bit clr);
      logic [31:0] s;
      logic [31:0] r;
      int  t0;
      bit  ok;
      t0 = txn_cnt;
      ok = (lat >= 1) && (lat <= TMO);
      wr_reg(3'd0, {8'h0, loc});
      wr_reg(3'd1, wd);
      tgt_lat = lat;
      wr_reg(3'd3, {20'h0, be, cmd, 4'h1});
      wait_idle(s);
      chk("R3 one bus cycle per start", txn_cnt - t0, 1);
      chk("R2 formed address", seen_addr, exp_addr(loc));
      chk("R3 command", {28'h0, seen_cmd}, {28'h0, cmd});
      chk("R3 byte enables", {28'h0, seen_be}, {28'h0, be});
      chk("R3 write data", seen_wdata, wd);
      exp_stat = exp_stat | (ok ? 2'b01 : 2'b10);
      chk(ok ? "R4 done status" : "R6 abort status", s, {30'h0, exp_stat});
      if (is_rd(cmd)) exp_rdat = ok ? tgt_data(exp_addr(loc)) : 32'hFFFF_FFFF;
      rd_reg(3'd2, r);
      chk(is_rd(cmd) ? (ok ? "R5 read capture" : "R7 abort fill")
                     : "R5 write keeps read-back", r, exp_rdat);
      if (clr) begin
         wr_reg(3'd5, s);
         exp_stat = 2'b00;
         rd_reg(3'd4, s);
         chk("R9 write-back clears", s, 32'h0);
      end
   endtask

   initial begin
      logic [31:0] v;
      int t0;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(3'd4, v); chk("R1 status after reset", v, 32'h0);
      rd_reg(3'd2, v); chk("R1 read-back after reset", v, 32'h0);
      rd_reg(3'd3, v); chk("R1 control after reset", v, 32'h0);
      chk("R1 request low", {31'h0, bus_req}, 32'h0);

      // R10 control readback, no launch without start bit
      wr_reg(3'd3, 32'h0000_0DA0);
      rd_reg(3'd3, v); chk("R10 control readback", v, 32'h0000_0DA0);
      rd_reg(3'd4, v); chk("R10 no launch without start", v, 32'h0);
      chk("R10 no request", {31'h0, bus_req}, 32'h0);

      // type-0 read, type-1 read with unaligned offset
      run_cycle(24'h00_18_10, 32'h0, 4'hA, 4'h0, 1, 1'b1);
      run_cycle(24'h05_21_47, 32'h0, 4'hA, be_for(1, 2'd3), 3, 1'b1);
      // write leaves read-back alone
      run_cycle(24'h00_08_0E, 32'h1234_5678, 4'hB, be_for(2, 2'd2), 2, 1'b1);
      // R6 boundary: last allowed cycle, then one too late
      run_cycle(24'h00_30_04, 32'h0, 4'h2, 4'h0, TMO, 1'b1);
      run_cycle(24'h02_30_04, 32'h0, 4'h2, 4'h0, TMO + 1, 1'b1);
      // R7: successful read, then aborted write must keep it
      run_cycle(24'h00_40_20, 32'h0, 4'hA, 4'h0, 4, 1'b1);
      run_cycle(24'h00_48_20, 32'hDEAD_BEEF, 4'h3, 4'h0, 0, 1'b1);

      // R8: busy and ignored start
      t0 = txn_cnt;
      wr_reg(3'd0, 32'h0000_5008);
      tgt_lat = 5;
      wr_reg(3'd3, 32'h0000_00A1);
      rd_reg(3'd4, v); chk("R8 busy during cycle", {31'h0, v[2]}, 32'h1);
      wr_reg(3'd3, 32'h0000_00B1);
      wait_idle(v);
      chk("R8 ignored start: one cycle", txn_cnt - t0, 1);
      chk("R8 command kept", {28'h0, seen_cmd}, 32'hA);
      chk("R8 done after cycle", v, 32'h1);
      exp_rdat = tgt_data(exp_addr(24'h00_50_08));
      rd_reg(3'd2, v); chk("R8 read-back of kept read", v, exp_rdat);
      repeat (3) @(negedge clk);
      chk("R8 no second request", {31'h0, bus_req}, 32'h0);
      chk("R8 no second cycle", txn_cnt - t0, 1);

      // R9 partial clears: done is set, add an abort
      exp_stat = 2'b01;
      run_cycle(24'h00_58_00, 32'h0, 4'h3, 4'h0, 0, 1'b0);
      wr_reg(3'd5, 32'h2);
      rd_reg(3'd4, v); chk("R9 clear abort only", v, 32'h1);
      wr_reg(3'd5, 32'h0);
      rd_reg(3'd4, v); chk("R9 zero write keeps", v, 32'h1);
      wr_reg(3'd5, 32'h1);
      rd_reg(3'd4, v); chk("R9 clear done", v, 32'h0);
      exp_stat = 2'b00;

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [3:0]  cmds [4];
         logic [23:0] loc;
         int sz;
         int lat;
         logic [3:0] cm;
         cmds[0] = 4'h2; cmds[1] = 4'h3; cmds[2] = 4'hA; cmds[3] = 4'hB;
         cm = cmds[$urandom() % 4];
         loc = $urandom();
         if ($urandom() % 2) loc[23:16] = 8'h00;
         case ($urandom() % 3)
            0: sz = 1;
            1: sz = 2;
            default: sz = 4;
         endcase
         if (sz == 2) loc[0] = 1'b0;
         if (sz == 4) loc[1:0] = 2'b00;
         lat = $urandom() % (TMO + 3);
         run_cycle(loc, $urandom(), cm, be_for(sz, loc[1:0]), lat, 1'b1);
      end

      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!ended) begin
         ended = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule